// File: doc/BRIEF.md
# Two-Bank Edge Interrupt Aggregator

The block collects up to 55 peripheral interrupt lines into one interrupt output and one wake output. Each source sits in one of two 32-bit banks. It is first synchronised, then edge-detected, and the detected edge is held in a pending bit. Software selects the edge sense of each source and enables the sources that may drive the interrupt line. It clears pending bits by writing ones to the status register.

A second detector on every source uses its own sense bit and enable bit. It raises a one-cycle wake pulse on a qualifying edge. Pending bits are not involved in this path. Writing a status register always drops the interrupt output for one cycle, so a parent controller that samples edges receives a fresh edge whenever work remains. Toggling a sense bit and then restoring it makes an edge on the sense-adjusted signal, and software can use this to re-trigger a source.

Registers are reached over a plain 32-bit bus with select, write flag and a word address. The top address bit picks the bank. The low three bits pick the register: 0 edge sense, 1 enable, 2 status, 3 wake sense, 4 wake enable. Codes 5 to 7 read zero. Reads are combinational. Writes take effect at the clock edge.

Top module: `edge_irq_agg`

## Requirements
- R1: Source k maps to bank k/32, bit k%32, and the bank is selected by address bit 3 (source 40 appears as bit 8 of the bank-1 status at address 4'hA).
- R2: Slots 27 to 31, and bank-1 bits above source 54, read zero in every register and ignore writes; inputs on those slots never become pending.
- R3: Reading a status register returns the pending bits; writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R4: An edge-sense bit of 0 detects a rising input and 1 detects a falling input; the opposite transition sets nothing.
- R5: irq_o is the registered OR over both banks of pending AND enable; a pending source with a clear enable bit leaves irq_o low.
- R6: A status write drives irq_o low in the cycle after it; one cycle later irq_o is high again if enabled bits remain pending.
- R7: Setting an edge-sense bit and then restoring it, with a steady input, leaves that source pending.
- R8: wake_o pulses high for exactly one cycle after an edge, in the wake-sense direction (0 rising, 1 falling), on a wake-enabled source; other transitions give no pulse.
- R9: After reset every register reads zero and both outputs are low.
- R10: A new edge detected in the same cycle as a write-one-to-clear of that bit leaves the bit pending.
- R11: Each input passes a two-flop synchroniser; a change driven between edges sets irq_o after the third rising clock edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw interrupt source lines |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Word address: {bank, register code} |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Aggregated interrupt request |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
Each edge-sense setting is driven with both a rising and a falling transition. This separates the detected direction from the ignored one and shows whether the sense bit really inverts detection. Sources in both banks, including a hole slot, are exercised so that the index mapping and the hole masking are distinguished. The clear pulse is tested with enabled work left pending and with none left. A clear is made to coincide with a fresh edge to show which of the two wins. The wake path is driven in both senses, and its pulses are counted over several cycles to confirm exactly one per qualifying edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned BANK_W = 32;

  typedef enum logic [2:0] {
    REG_POL  = 3'd0,
    REG_EN   = 3'd1,
    REG_STAT = 3'd2,
    REG_WPOL = 3'd3,
    REG_WEN  = 3'd4
  } reg_sel_e;

  // bit set where a source slot is implemented in bank 'bank'
  function automatic logic [BANK_W-1:0] impl_mask(input int unsigned bank,
                                                  input int unsigned nsrc,
                                                  input int unsigned hole_lo,
                                                  input int unsigned hole_hi);
    logic [BANK_W-1:0] m;
    int unsigned idx;
    m = '0;
    for (int unsigned k = 0; k < BANK_W; k++) begin
      idx  = bank * BANK_W + k;
      m[k] = (idx < nsrc) && !((idx >= hole_lo) && (idx <= hole_hi));
    end
    return m;
  endfunction
endpackage

// File: rtl/sync_edge.sv
module sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic pol_i,
  input  logic wpol_i,
  output logic edge_o,
  output logic wedge_o
);
  logic [1:0] sync_q;
  logic       adj_q, wadj_q;
  logic       adj, wadj;

  assign adj     = sync_q[1] ^ pol_i;
  assign wadj    = sync_q[1] ^ wpol_i;
  assign edge_o  = adj & ~adj_q;
  assign wedge_o = wadj & ~wadj_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      adj_q  <= 1'b0;
      wadj_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], d_i};
      adj_q  <= adj;
      wadj_q <= wadj;
    end
  end
endmodule

// File: rtl/edge_bank.sv
module edge_bank
  import irq_agg_pkg::*;
#(
  parameter logic [BANK_W-1:0] MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] src_i,
  input  logic              wr_pol_i,
  input  logic              wr_en_i,
  input  logic              wr_stat_i,
  input  logic              wr_wpol_i,
  input  logic              wr_wen_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] pol_o,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] pend_o,
  output logic [BANK_W-1:0] wpol_o,
  output logic [BANK_W-1:0] wen_o,
  output logic              act_now_o,
  output logic              act_nxt_o,
  output logic              wake_hit_o
);
  logic [BANK_W-1:0] pol_q, en_q, pend_q, wpol_q, wen_q;
  logic [BANK_W-1:0] edge_v, wedge_v, clr_v, pend_n;

  for (genvar i = 0; i < BANK_W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      sync_edge u_det (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (src_i[i]),
        .pol_i  (pol_q[i]),
        .wpol_i (wpol_q[i]),
        .edge_o (edge_v[i]),
        .wedge_o(wedge_v[i])
      );

      AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_v[i] |=> pend_q[i]); // R10
      AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat_i && wdata_i[i] && !edge_v[i]) |=> !pend_q[i]); // R3
    end else begin : g_hole
      logic unused_src;
      assign unused_src = src_i[i] ^ pol_q[i] ^ wpol_q[i];
      assign edge_v[i]  = 1'b0;
      assign wedge_v[i] = 1'b0;
    end
  end

  assign clr_v  = wr_stat_i ? wdata_i : '0;
  // a fresh edge wins over a clear in the same cycle
  assign pend_n = ((pend_q & ~clr_v) | edge_v) & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      wpol_q <= '0;
      wen_q  <= '0;
    end else begin
      pend_q <= pend_n;
      if (wr_pol_i)  pol_q  <= wdata_i & MASK;
      if (wr_en_i)   en_q   <= wdata_i & MASK;
      if (wr_wpol_i) wpol_q <= wdata_i & MASK;
      if (wr_wen_i)  wen_q  <= wdata_i & MASK;
    end
  end

  assign pol_o      = pol_q;
  assign en_o       = en_q;
  assign pend_o     = pend_q;
  assign wpol_o     = wpol_q;
  assign wen_o      = wen_q;
  assign act_now_o  = |(pend_q & en_q);
  assign act_nxt_o  = |(pend_n & en_q);
  assign wake_hit_o = |(wedge_v & wen_q);
endmodule

// File: rtl/irq_out.sv
module irq_out #(
  parameter int unsigned NUM_BANK = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_BANK-1:0] act_now_i,
  input  logic [NUM_BANK-1:0] act_nxt_i,
  input  logic [NUM_BANK-1:0] wake_hit_i,
  input  logic                clr_i,
  output logic                irq_o,
  output logic                wake_o
);
  logic irq_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      // any status write forces one low cycle
      irq_q  <= (|act_nxt_i) & ~clr_i;
      wake_q <= |wake_hit_i;
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o); // R6
  AST_ACTIVE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|act_now_i) && !clr_i) |=> irq_o); // R5
  AST_WAKE_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|wake_hit_i) |=> !wake_o); // R8
endmodule

// File: rtl/edge_irq_agg.sv
module edge_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 55,
  parameter int unsigned HOLE_LO = 27,
  parameter int unsigned HOLE_HI = 31,
  localparam int unsigned NUM_BANK = (NUM_SRC + BANK_W - 1) / BANK_W,
  localparam int unsigned BSEL_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int unsigned ADDR_W   = BSEL_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o,
  output logic               wake_o
);
  localparam int unsigned PAD_W = NUM_BANK * BANK_W;

  logic [PAD_W-1:0]  src_pad;
  logic [BSEL_W-1:0] bsel;
  reg_sel_e          rsel;
  logic              wr, clr_any;

  logic [BANK_W-1:0] pol_a  [NUM_BANK];
  logic [BANK_W-1:0] en_a   [NUM_BANK];
  logic [BANK_W-1:0] pend_a [NUM_BANK];
  logic [BANK_W-1:0] wpol_a [NUM_BANK];
  logic [BANK_W-1:0] wen_a  [NUM_BANK];
  logic [NUM_BANK-1:0] act_now, act_nxt, wake_hit;

  assign src_pad = PAD_W'(src_i);
  assign bsel    = addr_i[ADDR_W-1:3];
  assign rsel    = reg_sel_e'(addr_i[2:0]);
  assign wr      = sel_i & we_i;
  assign clr_any = wr & (rsel == REG_STAT);

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam logic [BANK_W-1:0] BMASK = impl_mask(b, NUM_SRC, HOLE_LO, HOLE_HI);
    logic hit;
    assign hit = wr & (bsel == BSEL_W'(b));

    edge_bank #(.MASK(BMASK)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_pad[b*BANK_W +: BANK_W]),
      .wr_pol_i  (hit & (rsel == REG_POL)),
      .wr_en_i   (hit & (rsel == REG_EN)),
      .wr_stat_i (hit & (rsel == REG_STAT)),
      .wr_wpol_i (hit & (rsel == REG_WPOL)),
      .wr_wen_i  (hit & (rsel == REG_WEN)),
      .wdata_i   (wdata_i),
      .pol_o     (pol_a[b]),
      .en_o      (en_a[b]),
      .pend_o    (pend_a[b]),
      .wpol_o    (wpol_a[b]),
      .wen_o     (wen_a[b]),
      .act_now_o (act_now[b]),
      .act_nxt_o (act_nxt[b]),
      .wake_hit_o(wake_hit[b])
    );

    AST_HOLE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && (bsel == BSEL_W'(b))) |-> ((rdata_o & ~BMASK) == '0)); // R2
  end

  always_comb begin
    rdata_o = '0;
    if (int'(bsel) < NUM_BANK) begin
      unique case (rsel)
        REG_POL:  rdata_o = pol_a[bsel];
        REG_EN:   rdata_o = en_a[bsel];
        REG_STAT: rdata_o = pend_a[bsel];
        REG_WPOL: rdata_o = wpol_a[bsel];
        REG_WEN:  rdata_o = wen_a[bsel];
        default:  rdata_o = '0;
      endcase
    end
  end

  irq_out #(.NUM_BANK(NUM_BANK)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_now_i (act_now),
    .act_nxt_i (act_nxt),
    .wake_hit_i(wake_hit),
    .clr_i     (clr_any),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );
endmodule

// File: tb/edge_irq_agg_tb.sv
module edge_irq_agg_tb;
  localparam logic [3:0] A_POL0 = 4'h0, A_EN0 = 4'h1, A_STAT0 = 4'h2, A_WPOL0 = 4'h3, A_WEN0 = 4'h4;
  localparam logic [3:0] A_EN1 = 4'h9, A_STAT1 = 4'hA;
  // {sense, start level, end level, expect pending}
  localparam logic [3:0] VEC [4] = '{4'b0011, 4'b0100, 4'b1101, 4'b1010};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [54:0] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;
  int          checks = 0, failures = 0;

  always #2 clk = ~clk;

  edge_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int          n;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R9 reset state
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 5; r++) begin
        rd(4'(b * 8 + r), v);
        chk("R9 reg reset", v, 32'h0);
      end
    end
    chk("R9 irq reset", {31'b0, irq}, 32'h0);
    chk("R9 wake reset", {31'b0, wake}, 32'h0);

    // R4 table of sense vs transition on source 3
    for (int i = 0; i < 4; i++) begin
      src[3] = VEC[i][2];
      wr(A_POL0, {28'b0, VEC[i][3], 3'b0});
      cyc(5);
      wr(A_STAT0, 32'hFFFF_FFFF);
      src[3] = VEC[i][1];
      cyc(5);
      rd(A_STAT0, v);
      chk("R4 sense table", {31'b0, v[3]}, {31'b0, VEC[i][0]});
    end
    wr(A_POL0, 32'h0);
    src[3] = 1'b0;
    cyc(5);
    wr(A_STAT0, 32'hFFFF_FFFF);
    cyc(2);

    // R11 / R5 latency through synchroniser
    wr(A_EN0, 32'h20);
    src[5] = 1'b1;
    cyc(2);
    chk("R11 irq not before third edge", {31'b0, irq}, 32'h0);
    cyc(1);
    chk("R11 irq after third edge", {31'b0, irq}, 32'h1);

    // R1 mapping of source 40
    src[40] = 1'b1;
    cyc(5);
    rd(A_STAT1, v);
    chk("R1 source 40 in bank 1 bit 8", v, 32'h100);
    rd(A_STAT0, v);
    chk("R1 bank 0 status", v, 32'h20);

    // R5 disabled pending does not drive irq
    wr(A_STAT0, 32'h20);
    cyc(3);
    chk("R5 disabled pending keeps irq low", {31'b0, irq}, 32'h0);
    wr(A_EN1, 32'h100);
    cyc(1);
    chk("R5 enable raises irq", {31'b0, irq}, 32'h1);

    // R6 clear pulse with work remaining
    src[5] = 1'b0;
    cyc(4);
    src[5] = 1'b1;
    cyc(5);
    wr(A_STAT0, 32'h20);
    chk("R6 irq low after clear", {31'b0, irq}, 32'h0);
    cyc(1);
    chk("R6 irq back high", {31'b0, irq}, 32'h1);
    rd(A_STAT0, v);
    chk("R3 write one clears", v, 32'h0);
    wr(A_STAT1, 32'h0);
    rd(A_STAT1, v);
    chk("R3 write zero keeps", v, 32'h100);
    wr(A_STAT1, 32'h100);
    cyc(3);
    chk("R6 irq stays low when nothing left", {31'b0, irq}, 32'h0);
    wr(A_EN0, 32'h0);
    wr(A_EN1, 32'h0);

    // R2 holes
    wr(A_EN0, 32'hFFFF_FFFF);
    rd(A_EN0, v);
    chk("R2 bank 0 enable holes", v, 32'h07FF_FFFF);
    wr(A_EN1, 32'hFFFF_FFFF);
    rd(A_EN1, v);
    chk("R2 bank 1 enable holes", v, 32'h007F_FFFF);
    wr(A_POL0, 32'hFFFF_FFFF);
    rd(A_POL0, v);
    chk("R2 bank 0 sense holes", v, 32'h07FF_FFFF);
    wr(A_POL0, 32'h0);
    wr(A_EN0, 32'h0);
    wr(A_EN1, 32'h0);
    cyc(4);
    wr(A_STAT0, 32'hFFFF_FFFF);
    wr(A_STAT1, 32'hFFFF_FFFF);
    src[28] = 1'b1;
    cyc(5);
    rd(A_STAT0, v);
    chk("R2 hole source never pending", v, 32'h0);

    // R7 retrigger by sense toggle
    wr(A_POL0, 32'h8);
    wr(A_POL0, 32'h0);
    cyc(3);
    rd(A_STAT0, v);
    chk("R7 toggle sets pending", v, 32'h8);

    // R10 edge coincident with clear
    wr(A_STAT0, 32'h8);
    @(negedge clk);
    src[3] = 1'b1;
    cyc(1);
    wr(A_STAT0, 32'h8);
    rd(A_STAT0, v);
    chk("R10 edge wins over clear", v, 32'h8);
    wr(A_STAT0, 32'h8);
    rd(A_STAT0, v);
    chk("R10 later clear works", v, 32'h0);

    // R8 wake rising
    wr(A_WEN0, 32'h40);
    cyc(3);
    src[6] = 1'b1;
    cyc(2);
    chk("R8 wake not early", {31'b0, wake}, 32'h0);
    cyc(1);
    chk("R8 wake pulse", {31'b0, wake}, 32'h1);
    cyc(1);
    chk("R8 wake one cycle", {31'b0, wake}, 32'h0);
    src[6] = 1'b0;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      if (wake) n++;
    end
    chk("R8 falling ignored with sense 0", n, 0);
    wr(A_WPOL0, 32'h40);
    cyc(4);
    src[6] = 1'b1;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      if (wake) n++;
    end
    chk("R8 rising ignored with sense 1", n, 0);
    src[6] = 1'b0;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      if (wake) n++;
    end
    chk("R8 falling pulses with sense 1", n, 1);

    finish_run();
  end
endmodule